// File: doc/BRIEF.md
# Multi-Mode Operand Address Resolver

This block fetches the source operand of a register-memory instruction. A request carries a mode code, an operand size, two register values (a base and an index) and a literal. The block works out where the operand lives, reads it from memory when needed, and returns the value with a one-cycle completion pulse. The ALU and the register file are outside the block. It is used as a front stage: the decoder supplies register contents and the literal, and the memory port answers each read through a request/valid handshake.

Two modes need more than a single address. Memory-indirect mode makes two dependent reads: first a pointer, then the operand at that pointer. The two auto-modify modes also report a new base value for the register file. Pre-decrement changes the base before the access. Post-increment accesses at the old base and bumps it afterwards. The amount added or removed is the operand size in bytes. Scaled mode uses the same size to shift the index.

Top module: `opnd_addr_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `mem_req`, `done` and `wb_en` are low.
- R2: Mode code 0 (register) returns `base_val` and code 1 (immediate) returns `imm_val`. Codes 10 to 15 behave as code 0. None of these issues a memory read, and `done` rises in the cycle after the start edge.
- R3: Mode code 2 (displacement) reads at `imm_val + base_val`.
- R4: Mode code 3 (register indirect) reads at `base_val`. Mode code 4 (indexed) reads at `base_val + index_val`.
- R5: Mode code 5 (direct) reads at `imm_val`.
- R6: Mode code 6 (memory indirect) reads first at `base_val`, then at the data returned by that read. The operand is the data from the second read.
- R7: Mode code 7 (post-increment) reads at `base_val` and reports a new base of `base_val + d`.
- R8: Mode code 8 (pre-decrement) reads at `base_val - d` and reports that same value as the new base. Arithmetic wraps modulo 2^W.
- R9: Mode code 9 (scaled) reads at `imm_val + base_val + (index_val << size)`, with the shift result truncated to W bits.
- R10: `size` codes 0, 1, 2 and 3 select d = 1, 2, 4 and 8 bytes.
- R11: Once raised, `mem_req` stays high with `mem_addr` unchanged until `mem_valid` is sampled high. A `mem_valid` pulse while `mem_req` is low has no effect.
- R12: `done` is a one-cycle pulse that carries `operand`. For memory modes the operand is the last returned data. `wb_en` is high only together with `done`, and only for codes 7 and 8. `mem_req` is low whenever `done` is high.
- R13: `start` is ignored while `busy` is high. A `start` in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving an operand; sampled when idle |
| mode | input | 4 | Addressing mode code |
| size | input | 2 | Operand size code, d = 1 << size |
| base_val | input | W | Base register contents |
| index_val | input | W | Index register contents |
| imm_val | input | W | Literal or displacement |
| busy | output | 1 | A memory-mode request is in progress |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | W | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data |
| done | output | 1 | Operand valid pulse |
| operand | output | W | Resolved operand |
| wb_en | output | 1 | Base register write-back enable |
| wb_val | output | W | New base register value |

## Verification
The completion of one request and the acceptance of the next can fall in the same cycle. In that cycle `done`, and possibly `wb_en` with the new base, goes out while a fresh `start` is captured. The bench provokes this by issuing the next request at the very sampling point where it sees `done`, with back-to-back issue chosen at random and in directed auto-modify sequences. It then judges both results separately: the write-back of the finishing request must be correct in that cycle, and the following request must resolve its own address and operand without interference.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [3:0] {
        AM_REG  = 4'd0,
        AM_IMM  = 4'd1,
        AM_DISP = 4'd2,
        AM_RIND = 4'd3,
        AM_IDX  = 4'd4,
        AM_DIR  = 4'd5,
        AM_MIND = 4'd6,
        AM_AINC = 4'd7,
        AM_ADEC = 4'd8,
        AM_SCL  = 4'd9
    } am_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2
    } st_e;

    typedef struct packed {
        logic needs_mem;
        logic chained;
        logic auto_wb;
    } mode_attr_t;

    function automatic am_e to_mode(input logic [3:0] code);
        if (code > 4'd9) return AM_REG;
        return am_e'(code);
    endfunction

    function automatic mode_attr_t attr_of(input am_e m);
        mode_attr_t a;
        a.needs_mem = !(m == AM_REG || m == AM_IMM);
        a.chained   = (m == AM_MIND);
        a.auto_wb   = (m == AM_AINC || m == AM_ADEC);
        return a;
    endfunction

    function automatic logic [3:0] size_bytes(input logic [1:0] szc);
        return 4'd1 << szc;
    endfunction

endpackage

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
#(
    parameter int W = 32
) (
    input  am_e          mode,
    input  logic [1:0]   szc,
    input  logic [W-1:0] base,
    input  logic [W-1:0] index,
    input  logic [W-1:0] imm,
    output logic [W-1:0] ea,
    output logic [W-1:0] wb_next,
    output logic [W-1:0] nomem_val
);
    localparam int PADW = W - 4;

    logic [W-1:0] step;
    logic [W-1:0] base_dec;
    logic [W-1:0] base_inc;
    logic [W-1:0] idx_scaled;

    always_comb begin
        step       = {{PADW{1'b0}}, size_bytes(szc)};
        base_dec   = base - step;
        base_inc   = base + step;
        idx_scaled = index << szc;
        unique case (mode)
            AM_DISP: ea = imm + base;
            AM_IDX:  ea = base + index;
            AM_DIR:  ea = imm;
            AM_ADEC: ea = base_dec;
            AM_SCL:  ea = imm + base + idx_scaled;
            default: ea = base;
        endcase
        wb_next   = (mode == AM_ADEC) ? base_dec : base_inc;
        nomem_val = (mode == AM_IMM) ? imm : base;
    end

endmodule

// File: rtl/eag_seq.sv
module eag_seq
    import eag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  mode_attr_t   attr,
    input  logic [W-1:0] ea,
    input  logic [W-1:0] wb_next,
    input  logic [W-1:0] nomem_val,
    input  logic         mem_valid,
    input  logic [W-1:0] mem_rdata,
    output logic         busy,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    output logic         done,
    output logic [W-1:0] operand,
    output logic         wb_en,
    output logic [W-1:0] wb_val
);
    st_e  state;
    logic chain_q;
    logic autowb_q;

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            operand  <= '0;
            wb_en    <= 1'b0;
            wb_val   <= '0;
            chain_q  <= 1'b0;
            autowb_q <= 1'b0;
        end else begin
            done  <= 1'b0;
            wb_en <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (attr.needs_mem) begin
                            state    <= ST_RD1;
                            mem_req  <= 1'b1;
                            mem_addr <= ea;
                            chain_q  <= attr.chained;
                            autowb_q <= attr.auto_wb;
                            wb_val   <= wb_next;
                        end else begin
                            done    <= 1'b1;
                            operand <= nomem_val;
                        end
                    end
                end
                ST_RD1: begin
                    if (mem_valid) begin
                        if (chain_q) begin
                            state    <= ST_RD2;
                            mem_addr <= mem_rdata;
                        end else begin
                            state   <= ST_IDLE;
                            mem_req <= 1'b0;
                            done    <= 1'b1;
                            operand <= mem_rdata;
                            wb_en   <= autowb_q;
                        end
                    end
                end
                ST_RD2: begin
                    if (mem_valid) begin
                        state   <= ST_IDLE;
                        mem_req <= 1'b0;
                        done    <= 1'b1;
                        operand <= mem_rdata;
                        wb_en   <= autowb_q;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    a_r11_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    a_r12_wb_with_done: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> done);

    a_r12_done_no_req: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

    a_r6_chain_addr: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD1 && chain_q && mem_valid) |=>
            (mem_req && mem_addr == $past(mem_rdata)));

    a_r13_req_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(start));

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
    import eag_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [3:0]   mode,
    input  logic [1:0]   size,
    input  logic [W-1:0] base_val,
    input  logic [W-1:0] index_val,
    input  logic [W-1:0] imm_val,
    output logic         busy,
    output logic         mem_req,
    output logic [W-1:0] mem_addr,
    input  logic         mem_valid,
    input  logic [W-1:0] mem_rdata,
    output logic         done,
    output logic [W-1:0] operand,
    output logic         wb_en,
    output logic [W-1:0] wb_val
);
    am_e          mode_d;
    mode_attr_t   attr_d;
    logic [W-1:0] ea_d;
    logic [W-1:0] wb_next_d;
    logic [W-1:0] nomem_d;

    assign mode_d = to_mode(mode);
    assign attr_d = attr_of(mode_d);

    eag_addr_calc #(.W(W)) u_calc (
        .mode      (mode_d),
        .szc       (size),
        .base      (base_val),
        .index     (index_val),
        .imm       (imm_val),
        .ea        (ea_d),
        .wb_next   (wb_next_d),
        .nomem_val (nomem_d)
    );

    eag_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .attr      (attr_d),
        .ea        (ea_d),
        .wb_next   (wb_next_d),
        .nomem_val (nomem_d),
        .mem_valid (mem_valid),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .done      (done),
        .operand   (operand),
        .wb_en     (wb_en),
        .wb_val    (wb_val)
    );

endmodule

// File: tb/opnd_addr_gen_tb.sv
`timescale 1ns/1ps
module opnd_addr_gen_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [3:0]   mode = '0;
    logic [1:0]   size = '0;
    logic [W-1:0] base_val = '0;
    logic [W-1:0] index_val = '0;
    logic [W-1:0] imm_val = '0;
    logic         busy;
    logic         mem_req;
    logic [W-1:0] mem_addr;
    logic         mem_valid = 1'b0;
    logic [W-1:0] mem_rdata = '0;
    logic         done;
    logic [W-1:0] operand;
    logic         wb_en;
    logic [W-1:0] wb_val;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] seen [4];
    int           nseen = 0;
    bit           pending = 0;
    int           wait_cnt = 0;
    logic [W-1:0] hold_addr = '0;
    bit           stray_req = 0;

    always #4 clk = ~clk;

    opnd_addr_gen #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .size(size),
        .base_val(base_val), .index_val(index_val), .imm_val(imm_val),
        .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .done(done),
        .operand(operand), .wb_en(wb_en), .wb_val(wb_val)
    );

    function automatic logic [W-1:0] mem_fn(input logic [W-1:0] a);
        return ({a[15:0], a[31:16]} ^ 32'hC3A5_0F1E) + (a * 32'd7);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory responder with random latency; also watches request stability (R11)
    initial begin
        forever begin
            @(negedge clk);
            if (mem_valid) begin
                mem_valid = 1'b0;
            end else if (mem_req) begin
                if (!pending) begin
                    pending   = 1;
                    hold_addr = mem_addr;
                    wait_cnt  = int'($urandom % 4);
                end else begin
                    chk(mem_addr == hold_addr, "R11 address held", mem_addr, hold_addr);
                end
                if (wait_cnt == 0) begin
                    mem_valid = 1'b1;
                    mem_rdata = mem_fn(mem_addr);
                    if (nseen < 4) seen[nseen] = mem_addr;
                    nseen++;
                    pending = 0;
                end else begin
                    wait_cnt--;
                end
            end else if (stray_req) begin
                mem_valid = 1'b1;
                mem_rdata = 32'hDEAD_BEEF;
                stray_req = 0;
            end
        end
    end

    // assumes the caller is at a negedge
    task automatic run_op(input logic [3:0] m, input logic [1:0] sz,
                          input logic [W-1:0] b, input logic [W-1:0] ix,
                          input logic [W-1:0] im, input bit poke);
        logic [W-1:0] d, ea, ea2, exp_op, exp_wb;
        int nreq, cyc;
        bit exp_wben;
        string tag;
        d = W'(1) << sz;   // R10
        ea = '0; ea2 = '0; nreq = 1; exp_wb = '0;
        exp_wben = (m == 4'd7 || m == 4'd8);
        case (m)
            4'd1:    begin nreq = 0; exp_op = im; tag = "R2 immediate"; end
            4'd2:    begin ea = im + b; tag = "R3 displacement"; end
            4'd3:    begin ea = b; tag = "R4 reg indirect"; end
            4'd4:    begin ea = b + ix; tag = "R4 indexed"; end
            4'd5:    begin ea = im; tag = "R5 direct"; end
            4'd6:    begin ea = b; ea2 = mem_fn(b); nreq = 2; tag = "R6 mem indirect"; end
            4'd7:    begin ea = b; exp_wb = b + d; tag = "R7 post-increment"; end
            4'd8:    begin ea = b - d; exp_wb = b - d; tag = "R8 pre-decrement"; end
            4'd9:    begin ea = im + b + (ix << sz); tag = "R9 scaled"; end
            default: begin nreq = 0; exp_op = b; tag = "R2 register"; end
        endcase
        if (nreq == 1) exp_op = mem_fn(ea);
        if (nreq == 2) exp_op = mem_fn(ea2);

        nseen = 0;
        start = 1'b1; mode = m; size = sz;
        base_val = b; index_val = ix; imm_val = im;
        @(negedge clk);
        start = 1'b0;
        mode = 4'($urandom); size = 2'($urandom);
        base_val = $urandom; index_val = $urandom; imm_val = $urandom;
        if (nreq == 0) chk(done, {tag, " done next cycle"}, W'(done), W'(1));
        cyc = 0;
        while (!done && cyc < 60) begin
            start = (poke && cyc == 0 && busy);
            if (start) mode = 4'd1;
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        chk(done, {tag, " R12 done"}, W'(done), W'(1));
        chk(operand == exp_op, {tag, " operand"}, operand, exp_op);
        chk(wb_en == exp_wben, {tag, " R12 wb_en"}, W'(wb_en), W'(exp_wben));
        chk(!mem_req, "R12 no request with done", W'(mem_req), W'(0));
        if (exp_wben) chk(wb_val == exp_wb, {tag, " new base"}, wb_val, exp_wb);
        chk(nseen == nreq, {tag, " read count"}, W'(nseen), W'(nreq));
        if (nreq >= 1 && nseen >= 1) chk(seen[0] == ea, {tag, " address"}, seen[0], ea);
        if (nreq == 2 && nseen >= 2) chk(seen[1] == ea2, "R6 second address", seen[1], ea2);
        if (poke) begin
            @(negedge clk);
            chk(!done && !busy && !mem_req, "R13 start while busy ignored",
                {29'd0, done, busy, mem_req}, '0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !done && !wb_en, "R1 reset outputs",
            {28'd0, busy, mem_req, done, wb_en}, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req && !done && !wb_en, "R1 after reset",
            {28'd0, busy, mem_req, done, wb_en}, '0);

        // directed: every mode
        run_op(4'd0, 2'd0, 32'h1234_5678, 32'h0, 32'h0, 0); @(negedge clk);
        run_op(4'd1, 2'd0, 32'h0, 32'h0, 32'hCAFE_0001, 0); @(negedge clk);
        run_op(4'd12, 2'd1, 32'hABCD_0000, 32'h5, 32'h9, 0); @(negedge clk);
        run_op(4'd2, 2'd2, 32'h0000_0040, 32'h0, 32'h0001_0002, 0); @(negedge clk);
        run_op(4'd3, 2'd2, 32'h0000_1000, 32'h7, 32'h3, 0); @(negedge clk);
        run_op(4'd4, 2'd2, 32'h0000_1000, 32'h0000_0230, 32'h3, 0); @(negedge clk);
        run_op(4'd5, 2'd3, 32'h55, 32'h66, 32'h0000_3E90, 0); @(negedge clk);
        run_op(4'd6, 2'd2, 32'h0000_2000, 32'h0, 32'h0, 0); @(negedge clk);
        run_op(4'd7, 2'd0, 32'h0000_0100, 32'h0, 32'h0, 0); @(negedge clk);
        run_op(4'd7, 2'd3, 32'hFFFF_FFFC, 32'h0, 32'h0, 0); @(negedge clk);
        run_op(4'd8, 2'd3, 32'h0000_0002, 32'h0, 32'h0, 0); @(negedge clk);
        run_op(4'd8, 2'd1, 32'h0000_0100, 32'h0, 32'h0, 0); @(negedge clk);
        run_op(4'd9, 2'd3, 32'h0000_0100, 32'h2000_0003, 32'h10, 0); @(negedge clk);
        run_op(4'd9, 2'd0, 32'h0000_0100, 32'h0000_0003, 32'h10, 0); @(negedge clk);

        // R13: start while busy, then back-to-back auto-modify in done cycle
        run_op(4'd6, 2'd2, 32'h0000_4444, 32'h0, 32'h0, 1);
        run_op(4'd8, 2'd2, 32'h0000_0800, 32'h0, 32'h0, 0);
        run_op(4'd7, 2'd2, 32'h0000_07FC, 32'h0, 32'h0, 0);
        run_op(4'd0, 2'd0, 32'h0000_0800, 32'h0, 32'h0, 0);
        @(negedge clk);

        // R11: stray valid while idle has no effect
        stray_req = 1;
        repeat (4) @(negedge clk);
        chk(!done && !busy && !mem_req, "R11 stray valid ignored",
            {29'd0, done, busy, mem_req}, '0);
        run_op(4'd3, 2'd0, 32'h0000_0ABC, 32'h0, 32'h0, 0); @(negedge clk);

        // constrained random
        void'($urandom(32'd2024));
        for (int i = 0; i < 400; i++) begin
            logic [3:0] m;
            m = 4'($urandom);
            run_op(m, 2'($urandom), $urandom, $urandom, $urandom, ($urandom % 8) == 0);
            if (($urandom % 3) != 0) @(negedge clk);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule